// File: doc/BRIEF.md
# Pipelined Static RAM Slave Controller

This block sits between an on-chip master that issues one-cycle commands and an external asynchronous static RAM that needs two clock cycles per access. The master pulses a read or write strobe for a single cycle with the address, and the write data for a write, valid only in that cycle. The controller captures everything it needs and drives the memory's address, write data and active-low select, output-enable and write-enable lines. It reports progress as a two-bit countdown of the cycles left until the read result is available or the write is complete. It does not use a single done pulse.

The read result is registered and stays on the master's data port until a later read result replaces it, so the master may pick it up whenever it suits. A second read may be issued while the first read's data is still being fetched, on the cycle the countdown shows 1. This sustains one read every two cycles. It needs no extra address or data register. Writes never overlap. A command that arrives while the controller cannot take it is dropped.

Top module: `sram_pipe_slave`

## Requirements
- R1: A read accepted while rdy_cnt_o is 0 drives ram_addr_o with the captured address and pulls ram_ncs_o and ram_noe_o low from the next cycle. rdy_cnt_o then reads 2, 1 and 0 on the three following cycles.
- R2: The memory word is sampled at the clock edge that ends the cycle in which rdy_cnt_o shows 1. It appears on rd_data_o with bits above the memory width at 0. rd_data_o keeps that value until the next read result.
- R3: A read issued while rdy_cnt_o is 1 and a read is in flight is accepted. On the next cycle the countdown restarts at 2 and ram_addr_o carries the new address. The previous result is presented on both of the cycles in which the countdown shows 2 and 1.
- R4: A write accepted while rdy_cnt_o is 0 drives ram_addr_o and ram_dout_o from the next cycle, with ram_dout_o holding the low memory-width bits of the write data. On those cycles ram_ncs_o is low and ram_noe_o is high, and rdy_cnt_o reads 2, 1 and 0.
- R5: ram_nwe_o is updated on the falling clock edge. It is low only from the middle of the first write access cycle to the middle of the second. It is never low while ram_noe_o is low, and the word is stored in memory.
- R6: When idle, rdy_cnt_o holds 0. While a transaction is in flight without a new accepted command, rdy_cnt_o decreases every cycle.
- R7: Two kinds of command are ignored: a write while rdy_cnt_o is non-zero, and a read while rdy_cnt_o is 2 or more or while the command in flight is a write. An ignored command changes neither the memory lines nor the countdown sequence nor the memory contents.
- R8: If rd_i and wr_i are both high, the read is taken and the write is dropped.
- R9: rd_pipe_lvl_o is constant 2 and wr_pipe_lvl_o is constant 0.
- R10: Synchronous active-high reset sets rdy_cnt_o and rd_data_o to 0 and deasserts ram_ncs_o, ram_noe_o and ram_nwe_o (high). A write cut short by reset does not store its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W | Word address, valid with a command strobe |
| wr_data_i | input | DATA_W | Write data, valid with wr_i |
| rd_i | input | 1 | One-cycle read command |
| wr_i | input | 1 | One-cycle write command |
| rd_data_o | output | DATA_W | Registered read result, zero-extended |
| rdy_cnt_o | output | 2 | Cycles remaining until completion, saturating at 3 |
| rd_pipe_lvl_o | output | 2 | Static read overlap level (2) |
| wr_pipe_lvl_o | output | 2 | Static write overlap level (0) |
| ram_addr_o | output | ADDR_W | Memory address |
| ram_dout_o | output | RAM_DW | Data driven toward memory on writes |
| ram_din_i | input | RAM_DW | Data returned by memory |
| ram_ncs_o | output | 1 | Memory select, active low |
| ram_noe_o | output | 1 | Memory output enable, active low |
| ram_nwe_o | output | 1 | Memory write enable, active low, falling-edge timed |

## Verification
Several properties are checked on every cycle:
- the countdown never rises without an accepted command;
- an idle countdown stays at 0;
- a dropped write or too-early read leaves the memory address and data lines untouched;
- an accepted read opens the memory with the captured address;
- rd_data_o moves only at the capture edge;
- write enable and output enable are never low together.

Some behaviours can only be shown by the directed scenarios: the exact 2, 1, 0 cadence, which value is presented during an overlapped read, the half-cycle placement of the write strobe, the zero-extension, and whether a write actually landed in memory or was dropped. Each of these is checked against a behavioural memory that returns valid data only once the address has been stable for a cycle.

// File: rtl/sram_slv_pkg.sv
`timescale 1ns/1ps
package sram_slv_pkg;
  typedef enum logic [0:0] {
    OP_RD = 1'b0,
    OP_WR = 1'b1
  } sram_op_e;

  localparam logic [1:0] RD_OVERLAP_LVL = 2'd2;
  localparam logic [1:0] WR_OVERLAP_LVL = 2'd0;
endpackage

// File: rtl/sram_slv_seq.sv
`timescale 1ns/1ps
module sram_slv_seq
  import sram_slv_pkg::*;
#(
  parameter int ACC_CYC = 2,
  localparam int CNT_W  = $clog2(ACC_CYC + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_i,
  input  logic       wr_i,
  output logic       take_rd,
  output logic       take_wr,
  output logic       capture,
  output logic       last,
  output logic       wr_win,
  output logic [1:0] rdy_cnt
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(ACC_CYC);

  logic [CNT_W-1:0] cnt;
  sram_op_e         op;
  logic             busy;

  assign busy    = (cnt != '0);
  assign last    = (cnt == ONE);
  // overlap only read behind read, on the final access cycle
  assign take_rd = rd_i && (!busy || (last && op == OP_RD));
  assign take_wr = wr_i && !rd_i && !busy;
  assign capture = last && (op == OP_RD);
  assign wr_win  = (op == OP_WR) && (cnt > ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      op  <= OP_RD;
    end else if (take_rd) begin
      cnt <= LOAD;
      op  <= OP_RD;
    end else if (take_wr) begin
      cnt <= LOAD;
      op  <= OP_WR;
    end else if (busy) begin
      cnt <= cnt - ONE;
    end
  end

  generate
    if (CNT_W == 2) begin : g_narrow
      assign rdy_cnt = cnt;
    end else begin : g_sat
      assign rdy_cnt = (|cnt[CNT_W-1:2]) ? 2'd3 : cnt[1:0];
    end
  endgenerate

  assert_countdown_R6: assert property (@(posedge clk) disable iff (rst)
    (rdy_cnt != 2'd0 && !rd_i && !wr_i) |=>
      (rdy_cnt < $past(rdy_cnt) || $past(rdy_cnt) == 2'd3));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (rdy_cnt == 2'd0 && !rd_i && !wr_i) |=> (rdy_cnt == 2'd0));
endmodule

// File: rtl/sram_slv_dpath.sv
`timescale 1ns/1ps
module sram_slv_dpath #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int RAM_DW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_rd,
  input  logic              take_wr,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [RAM_DW-1:0] ram_din_i,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [RAM_DW-1:0] ram_dout_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] din_ext;

  generate
    if (RAM_DW < DATA_W) begin : g_pad
      assign din_ext = {{(DATA_W-RAM_DW){1'b0}}, ram_din_i};
    end else begin : g_full
      assign din_ext = ram_din_i[DATA_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_addr_o <= '0;
      ram_dout_o <= '0;
      rd_data_o  <= '0;
    end else begin
      if (take_rd || take_wr) ram_addr_o <= addr_i;
      if (take_wr)            ram_dout_o <= wr_data_i[RAM_DW-1:0];
      if (capture)            rd_data_o  <= din_ext;
    end
  end

  assert_result_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(rd_data_o));
endmodule

// File: rtl/sram_slv_strb.sv
`timescale 1ns/1ps
module sram_slv_strb (
  input  logic clk,
  input  logic rst,
  input  logic take_rd,
  input  logic take_wr,
  input  logic last,
  input  logic wr_win,
  output logic ram_ncs_o,
  output logic ram_noe_o,
  output logic ram_nwe_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ram_ncs_o <= 1'b1;
      ram_noe_o <= 1'b1;
    end else if (take_rd) begin
      ram_ncs_o <= 1'b0;
      ram_noe_o <= 1'b0;
    end else if (take_wr) begin
      ram_ncs_o <= 1'b0;
      ram_noe_o <= 1'b1;
    end else if (last) begin
      ram_ncs_o <= 1'b1;
      ram_noe_o <= 1'b1;
    end
  end

  // half-cycle offset gives address setup and hold around the strobe
  always_ff @(negedge clk) begin
    if (rst) ram_nwe_o <= 1'b1;
    else     ram_nwe_o <= !wr_win;
  end

  assert_oe_we_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(!ram_noe_o && !ram_nwe_o));
endmodule

// File: rtl/sram_pipe_slave.sv
`timescale 1ns/1ps
module sram_pipe_slave
  import sram_slv_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 32,
  parameter int RAM_DW  = 16,
  parameter int ACC_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [1:0]        rdy_cnt_o,
  output logic [1:0]        rd_pipe_lvl_o,
  output logic [1:0]        wr_pipe_lvl_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [RAM_DW-1:0] ram_dout_o,
  input  logic [RAM_DW-1:0] ram_din_i,
  output logic              ram_ncs_o,
  output logic              ram_noe_o,
  output logic              ram_nwe_o
);
  logic take_rd, take_wr, capture, last, wr_win;

  assign rd_pipe_lvl_o = RD_OVERLAP_LVL;
  assign wr_pipe_lvl_o = WR_OVERLAP_LVL;

  sram_slv_seq #(.ACC_CYC(ACC_CYC)) u_seq (
    .clk(clk), .rst(rst), .rd_i(rd_i), .wr_i(wr_i),
    .take_rd(take_rd), .take_wr(take_wr), .capture(capture),
    .last(last), .wr_win(wr_win), .rdy_cnt(rdy_cnt_o)
  );

  sram_slv_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAM_DW(RAM_DW)) u_dpath (
    .clk(clk), .rst(rst), .take_rd(take_rd), .take_wr(take_wr),
    .capture(capture), .addr_i(addr_i), .wr_data_i(wr_data_i),
    .ram_din_i(ram_din_i), .ram_addr_o(ram_addr_o),
    .ram_dout_o(ram_dout_o), .rd_data_o(rd_data_o)
  );

  sram_slv_strb u_strb (
    .clk(clk), .rst(rst), .take_rd(take_rd), .take_wr(take_wr),
    .last(last), .wr_win(wr_win), .ram_ncs_o(ram_ncs_o),
    .ram_noe_o(ram_noe_o), .ram_nwe_o(ram_nwe_o)
  );

  assert_rd_open_R1: assert property (@(posedge clk) disable iff (rst)
    (rd_i && rdy_cnt_o == 2'd0) |=>
      (!ram_ncs_o && !ram_noe_o && ram_addr_o == $past(addr_i) && rdy_cnt_o != 2'd0));

  assert_wr_dropped_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !rd_i && rdy_cnt_o != 2'd0) |=> ($stable(ram_addr_o) && $stable(ram_dout_o)));

  assert_rd_dropped_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_i && rdy_cnt_o >= 2'd2) |=> $stable(ram_addr_o));

  assert_rd_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_i && wr_i && rdy_cnt_o == 2'd0) |=> (!ram_noe_o && $stable(ram_dout_o)));
endmodule

// File: tb/test_sram_pipe_slave.sv
`timescale 1ns/1ps
module test_sram_pipe_slave;
  localparam int AW = 10, DW = 32, MW = 16, DEPTH = 1 << AW;

  logic clk = 1'b0, rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdat = '0;
  logic rd = 1'b0, wr = 1'b0;
  logic [DW-1:0] rdat;
  logic [1:0] rdy, rpl, wpl;
  logic [AW-1:0] ram_addr;
  logic [MW-1:0] ram_dout, ram_din;
  logic ncs, noe, nwe;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sram_pipe_slave #(.ADDR_W(AW), .DATA_W(DW), .RAM_DW(MW), .ACC_CYC(2)) i_sram_pipe_slave (
    .clk(clk), .rst(rst), .addr_i(addr), .wr_data_i(wdat), .rd_i(rd), .wr_i(wr),
    .rd_data_o(rdat), .rdy_cnt_o(rdy), .rd_pipe_lvl_o(rpl), .wr_pipe_lvl_o(wpl),
    .ram_addr_o(ram_addr), .ram_dout_o(ram_dout), .ram_din_i(ram_din),
    .ram_ncs_o(ncs), .ram_noe_o(noe), .ram_nwe_o(nwe)
  );

  // behavioural memory: data valid once the address has been stable a cycle
  logic [MW-1:0] mem [DEPTH];
  logic [MW-1:0] shadow [DEPTH];
  logic [AW-1:0] prev_addr = '0;
  always @(posedge clk) prev_addr <= ram_addr;
  assign ram_din = (!ncs && !noe && prev_addr == ram_addr) ? mem[ram_addr] : 16'hDEAD;
  always @(posedge nwe) if (ncs === 1'b0) mem[ram_addr] <= ram_dout;

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i]    = MW'(i * 37 + 16'h5A00);
      shadow[i] = MW'(i * 37 + 16'h5A00);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ext(input logic [MW-1:0] v);
    return {{(DW-MW){1'b0}}, v};
  endfunction

  task automatic t_reset();
    chk("R10 rdy after reset", 32'(rdy), 0);
    chk("R10 rd_data after reset", rdat, 0);
    chk("R10 strobes after reset", {29'd0, ncs, noe, nwe}, 32'd7);
    chk("R9 read level", 32'(rpl), 2);
    chk("R9 write level", 32'(wpl), 0);
  endtask

  task automatic t_read(input logic [AW-1:0] a);
    rd = 1; addr = a; step(); rd = 0;
    chk("R1 cnt 2", 32'(rdy), 2);
    chk("R1 ncs/noe low", {30'd0, ncs, noe}, 0);
    chk("R1 ram addr", 32'(ram_addr), 32'(a));
    step(); chk("R1 cnt 1", 32'(rdy), 1);
    step(); chk("R1 cnt 0", 32'(rdy), 0);
    chk("R2 data zero-extended", rdat, ext(shadow[a]));
    chk("R1 ncs released", 32'(ncs), 1);
    step(); chk("R2 data held", rdat, ext(shadow[a]));
    chk("R6 idle cnt", 32'(rdy), 0);
  endtask

  task automatic t_pipe(input logic [AW-1:0] a, input logic [AW-1:0] b);
    rd = 1; addr = a; step(); rd = 0;
    step(); chk("R3 first cnt 1", 32'(rdy), 1);
    rd = 1; addr = b; step(); rd = 0;
    chk("R3 restart cnt 2", 32'(rdy), 2);
    chk("R3 first data c1", rdat, ext(shadow[a]));
    chk("R3 next addr", 32'(ram_addr), 32'(b));
    step(); chk("R3 cnt 1", 32'(rdy), 1);
    chk("R3 first data c2", rdat, ext(shadow[a]));
    step(); chk("R3 cnt 0", 32'(rdy), 0);
    chk("R3 second data", rdat, ext(shadow[b]));
  endtask

  task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr = 1; addr = a; wdat = d; step(); wr = 0;
    chk("R4 cnt 2", 32'(rdy), 2);
    chk("R4 ncs low noe high", {30'd0, ncs, noe}, 1);
    chk("R4 ram addr", 32'(ram_addr), 32'(a));
    chk("R4 ram dout low bits", 32'(ram_dout), 32'(d[MW-1:0]));
    #2; chk("R5 nwe low mid first", 32'(nwe), 0);
    step(); chk("R4 cnt 1", 32'(rdy), 1);
    #2; chk("R5 nwe high mid second", 32'(nwe), 1);
    step(); chk("R4 cnt 0", 32'(rdy), 0);
    shadow[a] = d[MW-1:0];
  endtask

  task automatic t_wr_during_rd(input logic [AW-1:0] a, input logic [AW-1:0] x);
    logic [MW-1:0] dout_before;
    dout_before = ram_dout;
    rd = 1; addr = a; step(); rd = 0;
    wr = 1; addr = x; wdat = 32'h0000_BEEF; step(); wr = 0;
    chk("R7 cnt 1 after dropped write", 32'(rdy), 1);
    chk("R7 dout unchanged", 32'(ram_dout), 32'(dout_before));
    chk("R7 still reading", 32'(noe), 0);
    step(); chk("R7 read completes", rdat, ext(shadow[a]));
    step();
    t_read(x);
  endtask

  task automatic t_rd_during_wr(input logic [AW-1:0] a, input logic [AW-1:0] b);
    wr = 1; addr = a; wdat = 32'h0000_7711; step(); wr = 0;
    step();
    rd = 1; addr = b; step(); rd = 0;
    chk("R7 read behind write dropped", 32'(rdy), 0);
    chk("R7 ncs idle", 32'(ncs), 1);
    shadow[a] = 16'h7711;
    step();
  endtask

  task automatic t_rd_early(input logic [AW-1:0] a, input logic [AW-1:0] b);
    rd = 1; addr = a; step(); rd = 0;
    rd = 1; addr = b; step(); rd = 0;
    chk("R7 early read cnt", 32'(rdy), 1);
    chk("R7 early read addr kept", 32'(ram_addr), 32'(a));
    step(); chk("R7 early read cnt 0", 32'(rdy), 0);
    chk("R7 first result", rdat, ext(shadow[a]));
    step(); chk("R7 no second result", 32'(rdy), 0);
  endtask

  task automatic t_both(input logic [AW-1:0] a);
    rd = 1; wr = 1; addr = a; wdat = 32'h0000_0F0F; step(); rd = 0; wr = 0;
    chk("R8 read taken", 32'(noe), 0);
    chk("R8 cnt 2", 32'(rdy), 2);
    step(); step();
    chk("R8 read result", rdat, ext(shadow[a]));
    step();
    t_read(a);
  endtask

  task automatic t_reset_mid_write(input logic [AW-1:0] a);
    wr = 1; addr = a; wdat = 32'h0000_C0DE; step(); wr = 0;
    rst = 1; step(); rst = 0;
    chk("R10 cnt cleared", 32'(rdy), 0);
    chk("R10 strobes released", {29'd0, ncs, noe, nwe}, 32'd7);
    step();
    t_read(a);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    step(); step(); rst = 0; step();
    t_reset();
    t_read(10'd5);
    t_read(10'd1023);
    t_pipe(10'd7, 10'd300);
    t_write(10'd42, 32'hABCD_1234);
    t_read(10'd42);
    t_write(10'd43, 32'h0000_0001);
    t_pipe(10'd42, 10'd43);
    t_wr_during_rd(10'd8, 10'd9);
    t_rd_during_wr(10'd20, 10'd21);
    t_read(10'd20);
    t_rd_early(10'd30, 10'd31);
    t_both(10'd60);
    t_reset_mid_write(10'd70);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule